// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block steps a simple processor through the clock periods of each instruction and runs the external bus handshake at the end of the instruction. A start request taken while the sequencer is idle latches the instruction's length class, its access flags and the accumulator value. One clock later the instruction enters period CK1. The length class sets how many clocks the instruction takes (2, 3 or 4), and CK4 is always the last period. Two-clock internal operations such as register move or add go straight from CK1 to CK4.

CK4 is also the bus period. If the instruction reads or writes the operand bus, the data strobe is high for all of CK4. If the instruction writes to instruction memory, the instruction-port write enable is high for all of CK4. In both cases the latched accumulator value is on the 20-bit instruction address bus from the start of CK1. An instruction with either kind of access stays in CK4 until the active-low acknowledge is sampled low, or until a bus error or memory-protect error is sampled high. There is no limit on how long it can stay there, and the busy status stays high for the whole time. When the instruction finishes, a 2-bit code reports what ended it.

Top module: `bus_cycle_seq`

## Requirements
- R1: When rst_ni is low, the sequencer is idle. phase_o, busy_o, ds_o, iwe_o, done_o, term_o and iaddr_o are all zero.
- R2: If start_i is high at a rising edge while idle, then after that edge phase_o is 4'b0001 (CK1) and busy_o is 1. iaddr_o shows the acc_i value sampled at that edge and holds it through the instruction, even if acc_i changes.
- R3: phase_o is one-hot: bit 0 = CK1, bit 1 = CK2, bit 2 = CK3, bit 3 = CK4. Each period lasts one clock before CK4. The order depends on len_i: len_i=0 gives CK1,CK4; len_i=1 gives CK1,CK2,CK4; len_i=2 or 3 gives CK1,CK2,CK3,CK4.
- R4: If op_i and st_i were both 0 at start, CK4 lasts exactly one clock. ack_ni, berr_i and mprot_i are ignored and term_o becomes 2'b00.
- R5: For all of CK4, wait clocks included, ds_o equals the latched op_i and iwe_o equals the latched st_i. Both are 0 outside CK4.
- R6: In CK4 of an access instruction (op_i or st_i latched), a rising edge that sees ack_ni=1, berr_i=0 and mprot_i=0 keeps the sequencer in CK4 with busy_o=1.
- R7: In CK4 of an access instruction, a rising edge that sees ack_ni=0, berr_i=1 or mprot_i=1 returns the sequencer to idle. done_o is then high for exactly one clock. term_o gets 00 (acknowledge), 01 (bus error) or 10 (memory protect) and keeps it until the next instruction ends.
- R8: When several termination inputs are active on the same edge, bus error wins over memory protect, and memory protect wins over acknowledge.
- R9: start_i is ignored while busy_o is 1. The phase order and iaddr_o are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| len_i | input | 2 | Length class: 0=2 clocks, 1=3 clocks, 2/3=4 clocks |
| op_i | input | 1 | Instruction uses the operand bus in CK4 |
| st_i | input | 1 | Instruction stores to instruction memory in CK4 |
| acc_i | input | 20 | Accumulator value, used as the instruction address |
| ack_ni | input | 1 | Transfer acknowledge, active low |
| berr_i | input | 1 | Bus error, active high |
| mprot_i | input | 1 | Memory-protect error, active high |
| phase_o | output | 4 | One-hot period indicator, CK1..CK4 |
| busy_o | output | 1 | Instruction executing (CK1 to end of CK4) |
| ds_o | output | 1 | Operand data strobe, active high |
| iwe_o | output | 1 | Instruction-port write enable, active high |
| iaddr_o | output | 20 | Instruction address bus |
| term_o | output | 2 | Code of the event that ended the last instruction |
| done_o | output | 1 | One-clock pulse after an instruction ends |

## Verification
A start sampled at a rising edge shows up as CK1 and the latched address right after that edge. Each later period advances exactly one edge after the previous one. The termination inputs are sampled at a CK4 edge, and idle, done_o and the new term_o all appear right after that same edge. done_o drops after the next edge. The bench drives every input one time unit after a rising edge and reads every output at that same point, so each expected value is checked in the first cycle it is due. Wait loops count the exact number of stalled edges before the termination inputs are applied.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CK1  = 3'd1,
    PH_CK2  = 3'd2,
    PH_CK3  = 3'd3,
    PH_CK4  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    TERM_ACK   = 2'b00,
    TERM_BERR  = 2'b01,
    TERM_MPROT = 2'b10
  } term_e;

  localparam logic [1:0] LEN_2CLK = 2'd0;
  localparam logic [1:0] LEN_3CLK = 2'd1;
endpackage

// File: rtl/bcs_term_arb.sv
module bcs_term_arb
  import bcs_pkg::*;
(
  input  logic  ack_ni,
  input  logic  berr_i,
  input  logic  mprot_i,
  output logic  hit_o,
  output term_e code_o
);
  // fixed priority: bus error, then protect, then acknowledge
  always_comb begin
    hit_o  = berr_i | mprot_i | ~ack_ni;
    if (berr_i)       code_o = TERM_BERR;
    else if (mprot_i) code_o = TERM_MPROT;
    else              code_o = TERM_ACK;
  end
endmodule

// File: rtl/bcs_instr_reg.sv
module bcs_instr_reg #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              op_i,
  input  logic              st_i,
  input  logic [ADDR_W-1:0] acc_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              op_o,
  output logic              st_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o  <= '0;
      op_o   <= 1'b0;
      st_o   <= 1'b0;
      addr_o <= '0;
    end else if (load_i) begin
      len_o  <= len_i;
      op_o   <= op_i;
      st_o   <= st_i;
      addr_o <= acc_i;
    end
  end
endmodule

// File: rtl/bcs_phase_ctrl.sv
module bcs_phase_ctrl
  import bcs_pkg::*;
#(
  parameter int LEN_W  = 2,
  parameter int NUM_PH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              access_i,
  input  logic              hit_i,
  input  term_e             code_i,
  output logic              load_o,
  output logic [NUM_PH-1:0] phase_o,
  output logic              done_o,
  output term_e             term_o
);
  phase_e state_q, state_d;
  logic   fin;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    fin     = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = PH_CK1;
      end
      PH_CK1:  state_d = (len_i == LEN_2CLK) ? PH_CK4 : PH_CK2;
      PH_CK2:  state_d = (len_i == LEN_3CLK) ? PH_CK4 : PH_CK3;
      PH_CK3:  state_d = PH_CK4;
      PH_CK4:  if (!access_i || hit_i) begin
        fin     = 1'b1;
        state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      done_o  <= 1'b0;
      term_o  <= TERM_ACK;
    end else begin
      state_q <= state_d;
      done_o  <= fin;
      if (fin) term_o <= access_i ? code_i : TERM_ACK;
    end
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    assign phase_o[g] = (state_q == phase_e'(3'(g + 1)));
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 2,
  parameter int NUM_PH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              op_i,
  input  logic              st_i,
  input  logic [ADDR_W-1:0] acc_i,
  input  logic              ack_ni,
  input  logic              berr_i,
  input  logic              mprot_i,
  output logic [NUM_PH-1:0] phase_o,
  output logic              busy_o,
  output logic              ds_o,
  output logic              iwe_o,
  output logic [ADDR_W-1:0] iaddr_o,
  output logic [1:0]        term_o,
  output logic              done_o
);
  localparam int LAST = NUM_PH - 1;

  logic             load;
  logic [LEN_W-1:0] len_q;
  logic             op_q, st_q, access;
  logic             hit;
  term_e            code, term_q;

  bcs_instr_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_instr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len_i),
    .op_i   (op_i),
    .st_i   (st_i),
    .acc_i  (acc_i),
    .len_o  (len_q),
    .op_o   (op_q),
    .st_o   (st_q),
    .addr_o (iaddr_o)
  );

  bcs_term_arb u_arb (
    .ack_ni  (ack_ni),
    .berr_i  (berr_i),
    .mprot_i (mprot_i),
    .hit_o   (hit),
    .code_o  (code)
  );

  assign access = op_q | st_q;

  bcs_phase_ctrl #(.LEN_W(LEN_W), .NUM_PH(NUM_PH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .len_i    (len_q),
    .access_i (access),
    .hit_i    (hit),
    .code_i   (code),
    .load_o   (load),
    .phase_o  (phase_o),
    .done_o   (done_o),
    .term_o   (term_q)
  );

  assign term_o = term_q;
  assign busy_o = |phase_o;
  assign ds_o   = phase_o[LAST] & op_q;
  assign iwe_o  = phase_o[LAST] & st_q;

  assert_start_ck1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (phase_o == NUM_PH'(1) && iaddr_o == $past(acc_i)));

  assert_phase_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_o));

  assert_short_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[0] && len_q == LEN_2CLK) |=> phase_o[LAST]);

  assert_ck4_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[LAST] && access && ack_ni && !berr_i && !mprot_i)
      |=> (phase_o[LAST] && busy_o && $stable(ds_o) && $stable(iwe_o)));

  assert_ck4_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[LAST] && (!access || !ack_ni || berr_i || mprot_i)) |=> (!busy_o && done_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_berr_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[LAST] && access && berr_i) |=> (term_o == 2'b01));

  assert_mprot_over_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[LAST] && access && !berr_i && mprot_i) |=> (term_o == 2'b10));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !phase_o[LAST] && start_i) |=> (busy_o && $stable(iaddr_o)));
endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  len_i = '0;
  logic        op_i = 1'b0, st_i = 1'b0;
  logic [19:0] acc_i = '0;
  logic        ack_ni = 1'b1, berr_i = 1'b0, mprot_i = 1'b0;
  logic [3:0]  phase_o;
  logic        busy_o, ds_o, iwe_o, done_o;
  logic [19:0] iaddr_o;
  logic [1:0]  term_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  bus_cycle_seq u_bus_cycle_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .op_i(op_i), .st_i(st_i), .acc_i(acc_i), .ack_ni(ack_ni),
    .berr_i(berr_i), .mprot_i(mprot_i), .phase_o(phase_o), .busy_o(busy_o),
    .ds_o(ds_o), .iwe_o(iwe_o), .iaddr_o(iaddr_o), .term_o(term_o), .done_o(done_o)
  );

  // kind: 0 ack, 1 bus error, 2 protect, 3 all three, 4 ack+protect
  typedef struct packed {
    logic [1:0]  len;
    logic        op;
    logic        st;
    logic [3:0]  waits;
    logic [2:0]  kind;
    logic [19:0] acc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 4'd0, 3'd0, 20'h12345},
    '{2'd1, 1'b1, 1'b0, 4'd0, 3'd0, 20'hABCDE},
    '{2'd2, 1'b1, 1'b0, 4'd3, 3'd0, 20'h00001},
    '{2'd3, 1'b0, 1'b1, 4'd2, 3'd1, 20'hFFFFF},
    '{2'd1, 1'b1, 1'b0, 4'd5, 3'd2, 20'h55555},
    '{2'd0, 1'b1, 1'b1, 4'd1, 3'd3, 20'hAAAAA},
    '{2'd2, 1'b1, 1'b0, 4'd0, 3'd4, 20'h0F0F0},
    '{2'd0, 1'b0, 1'b1, 4'd0, 3'd2, 20'h80000},
    '{2'd2, 1'b0, 1'b0, 4'd0, 3'd1, 20'h13579}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle_terms();
    ack_ni = 1'b1; berr_i = 1'b0; mprot_i = 1'b0;
  endtask

  task automatic drive_kind(logic [2:0] k);
    idle_terms();
    case (k)
      3'd0: ack_ni = 1'b0;
      3'd1: berr_i = 1'b1;
      3'd2: mprot_i = 1'b1;
      3'd3: begin ack_ni = 1'b0; berr_i = 1'b1; mprot_i = 1'b1; end
      default: begin ack_ni = 1'b0; mprot_i = 1'b1; end
    endcase
  endtask

  function automatic logic [1:0] exp_code(logic [2:0] k);
    case (k)
      3'd1, 3'd3: return 2'b01;
      3'd2, 3'd4: return 2'b10;
      default:    return 2'b00;
    endcase
  endfunction

  task automatic run_vec(vec_t v);
    logic acc_en = v.op | v.st;
    len_i = v.len; op_i = v.op; st_i = v.st; acc_i = v.acc; start_i = 1'b1;
    idle_terms();
    tick();
    start_i = 1'b0;
    acc_i = ~v.acc;
    chk("R2 ck1", 32'(phase_o), 32'h1);
    chk("R2 busy", 32'(busy_o), 32'h1);
    chk("R2 addr", 32'(iaddr_o), 32'(v.acc));
    if (v.len != 2'd0) begin
      tick(); chk("R3 ck2", 32'(phase_o), 32'h2);
      chk("R5 no strobe outside ck4", 32'({ds_o, iwe_o}), 32'h0);
    end
    if (v.len >= 2'd2) begin
      tick(); chk("R3 ck3", 32'(phase_o), 32'h4);
    end
    if (!acc_en) drive_kind(v.kind);
    if (!acc_en && v.kind == 3'd0) ack_ni = 1'b1;
    tick();
    chk("R3 ck4", 32'(phase_o), 32'h8);
    chk("R5 ds", 32'(ds_o), 32'(v.op));
    chk("R5 iwe", 32'(iwe_o), 32'(v.st));
    if (acc_en) begin
      for (int i = 0; i < int'(v.waits); i++) begin
        tick();
        chk("R6 wait ck4", 32'(phase_o), 32'h8);
        chk("R6 busy", 32'(busy_o), 32'h1);
        chk("R5 ds wait", 32'({ds_o, iwe_o}), 32'({v.op, v.st}));
        chk("R2 addr hold", 32'(iaddr_o), 32'(v.acc));
      end
      drive_kind(v.kind);
    end
    tick();
    idle_terms();
    chk("R7 idle", 32'(phase_o), 32'h0);
    chk("R7 done", 32'(done_o), 32'h1);
    if (acc_en) chk("R7 R8 code", 32'(term_o), 32'(exp_code(v.kind)));
    else        chk("R4 code ok", 32'(term_o), 32'h0);
    tick();
    chk("R7 done pulse", 32'(done_o), 32'h0);
    chk("R7 code held", 32'(term_o), acc_en ? 32'(exp_code(v.kind)) : 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #23;
    chk("R1 phase", 32'(phase_o), 32'h0);
    chk("R1 outs", 32'({busy_o, ds_o, iwe_o, done_o}), 32'h0);
    chk("R1 term", 32'(term_o), 32'h0);
    chk("R1 addr", 32'(iaddr_o), 32'h0);
    rst_ni = 1'b1;
    tick();

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R9: start held high through an instruction
    len_i = 2'd1; op_i = 1'b0; st_i = 1'b0; acc_i = 20'h2468A; start_i = 1'b1;
    tick();
    chk("R9 ck1", 32'(phase_o), 32'h1);
    acc_i = 20'h11111; len_i = 2'd2;
    tick();
    chk("R9 no restart", 32'(phase_o), 32'h2);
    chk("R9 addr", 32'(iaddr_o), 32'h2468A);
    start_i = 1'b0;
    tick();
    chk("R9 len kept", 32'(phase_o), 32'h8);
    tick();
    chk("R9 end", 32'(phase_o), 32'h0);
    tick();

    // R1: asynchronous reset during a stalled CK4
    len_i = 2'd0; op_i = 1'b1; st_i = 1'b1; acc_i = 20'h3C3C3; start_i = 1'b1;
    idle_terms();
    tick(); start_i = 1'b0;
    tick(); tick();
    chk("R6 stalled", 32'(phase_o), 32'h8);
    rst_ni = 1'b0;
    #1;
    chk("R1 reset phase", 32'(phase_o), 32'h0);
    chk("R1 reset strobes", 32'({ds_o, iwe_o, busy_o}), 32'h0);
    chk("R1 reset addr", 32'(iaddr_o), 32'h0);
    tick();
    rst_ni = 1'b1;
    tick();
    run_vec(VEC[5]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule